// File: doc/BRIEF.md
# Audio CPU I/O Register Decoder

This block sits beside an 8-bit audio processor and interprets the sixteen-byte register window at F0h–FFh of its 64 KB address space. A control register at offset 1 drives the three timer enables and the boot ROM overlay select. Setting its pair-clear bits also zeroes the host-written input ports. Offset 2 holds an address latch for the sound DSP, and offset 3 is the data path to the DSP register it selects. Offsets 4–7 read back the four host input ports, and offsets 8 and 9 are plain scratch storage.

Every CPU write is passed on to the underlying RAM, including writes that land in the window or under the ROM. Reads return one of three things: register state, a ROM byte when the overlay is on and the address is in the top ROM region, or the RAM data for any other address. The ROM contents are generated by a formula. A host-side load path fills the four input ports. The timers, the DSP and the RAM are outside the block.

Top module: `aud_io_decode`

## Requirements
- R1: After reset, rom_on is 1, timer_en is 0, and reads of offsets 2, 4–7, 8 and 9 (addresses 00F2h, 00F4h–00F7h, 00F8h, 00F9h) return 00h.
- R2: A CPU write to 00F1h sets timer_en to data bits 2:0 and rom_on to data bit 7. Both are visible from the next clock edge.
- R3: A write to 00F1h with bit 4 set clears host ports 0 and 1, and with bit 5 set clears ports 2 and 3. Ports outside the selected pair keep their value. The clear wins over a host load in the same cycle.
- R4: A write to 00F2h stores all 8 data bits in the DSP address latch. A read of 00F2h returns all 8 bits, and dsp_addr always shows the latch bits 6:0.
- R5: A CPU write to 00F3h raises dsp_we in the same cycle with dsp_wdata equal to the CPU data, but only when latch bit 7 is 0. When latch bit 7 is 1, dsp_we stays 0.
- R6: A CPU read of 00F3h raises dsp_re in the same cycle and returns dsp_rdata on cpu_rdata. dsp_addr is the latch masked to 7 bits.
- R7: Writes to 00F8h and 00F9h are stored, and reads of those addresses return the stored bytes.
- R8: ram_we equals 1 in every cycle with a CPU write, whatever the address, and 0 otherwise.
- R9: A read of 00F4h+n (n = 0..3) returns host port n, which a host load with host_sel = n sets. The RAM data is not returned for these addresses.
- R10: While rom_on is 1, a read of an address at or above 10000h − ROM_BYTES (FFC0h by default) returns byte (ROM_SEED + ROM_STEP × i) mod 256, where i is the address minus that base. The defaults are ROM_SEED = 5Bh and ROM_STEP = 37. While rom_on is 0, the same read returns ram_rdata.
- R11: Reads of window offsets 0, 1 and Ah–Fh, and reads of any address outside the window and the active ROM region, return ram_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU (combinational) |
| ram_we | output | 1 | Write enable to the underlying RAM |
| ram_rdata | input | 8 | Data read from the underlying RAM |
| dsp_addr | output | 7 | DSP register address (latch bits 6:0) |
| dsp_wdata | output | 8 | DSP write data |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_re | output | 1 | DSP register read strobe |
| dsp_rdata | input | 8 | DSP register read data |
| host_we | input | 1 | Host load strobe for an input port |
| host_sel | input | 2 | Host port index |
| host_wdata | input | 8 | Host port data |
| timer_en | output | 3 | Timer enables |
| rom_on | output | 1 | Boot ROM overlay active |

## Verification
The embedded properties check, cycle by cycle, the effects of a register write one edge later: the control bits, the pair clears of the host ports, the DSP address latch and the scratch bytes. They also check that a DSP write right after an address with bit 7 set is suppressed. The read mux is left to the bench's scenarios. These cover ROM overlay selection before and after the overlay is disabled, RAM fall-through for unused offsets, and the priority between a clear and a simultaneous host load. Long random mixes of control, latch and host traffic are compared against a reference model kept in the bench.

// File: rtl/aud_io_decode.sv
module aud_io_decode #(
  parameter int         ROM_BYTES = 64,
  parameter logic [7:0] ROM_SEED  = 8'h5B,
  parameter logic [7:0] ROM_STEP  = 8'd37
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic [7:0]  cpu_rdata,
  output logic        ram_we,
  input  logic [7:0]  ram_rdata,
  output logic [6:0]  dsp_addr,
  output logic [7:0]  dsp_wdata,
  output logic        dsp_we,
  output logic        dsp_re,
  input  logic [7:0]  dsp_rdata,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [7:0]  host_wdata,
  output logic [2:0]  timer_en,
  output logic        rom_on
);
  localparam int          ROM_AW     = $clog2(ROM_BYTES);
  localparam int          ROM_BASE_I = 65536 - ROM_BYTES;
  localparam logic [15:0] ROM_BASE   = ROM_BASE_I[15:0];

  logic       win;
  logic [3:0] off;
  logic       wr_ctrl, wr_latch, wr_dsp, rd_dsp;
  logic [7:0] latch_q;
  logic [7:0] scr_q [2];
  logic [7:0] host_q [4];
  logic [2:0] ten_q;
  logic       rom_q;
  logic [ROM_AW-1:0] rom_idx;
  logic [7:0] rom_byte;

  assign win      = (cpu_addr[15:4] == 12'h00F);
  assign off      = cpu_addr[3:0];
  assign wr_ctrl  = cpu_wr && win && (off == 4'h1);
  assign wr_latch = cpu_wr && win && (off == 4'h2);
  assign wr_dsp   = cpu_wr && win && (off == 4'h3);
  assign rd_dsp   = cpu_rd && win && (off == 4'h3);

  assign ram_we    = cpu_wr;
  assign dsp_addr  = latch_q[6:0];
  assign dsp_wdata = cpu_wdata;
  assign dsp_we    = wr_dsp && !latch_q[7];
  assign dsp_re    = rd_dsp;
  assign timer_en  = ten_q;
  assign rom_on    = rom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ten_q   <= '0;
      rom_q   <= 1'b1;
      latch_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ten_q <= cpu_wdata[2:0];
        rom_q <= cpu_wdata[7];
      end
      if (wr_latch) latch_q <= cpu_wdata;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rst_n) scr_q[s] <= '0;
      else if (cpu_wr && win && (off == 4'(8 + s))) scr_q[s] <= cpu_wdata;
    end
  end

  for (genvar p = 0; p < 4; p++) begin : g_host
    always_ff @(posedge clk) begin
      if (!rst_n) host_q[p] <= '0;
      else if (wr_ctrl && cpu_wdata[4 + p/2]) host_q[p] <= '0;
      else if (host_we && host_sel == 2'(p)) host_q[p] <= host_wdata;
    end
  end

  assign rom_idx  = cpu_addr[ROM_AW-1:0];
  assign rom_byte = ROM_SEED + ROM_STEP * 8'(rom_idx);

  always_comb begin
    cpu_rdata = ram_rdata;
    if (rom_q && cpu_addr >= ROM_BASE) cpu_rdata = rom_byte;
    else if (win) begin
      case (off)
        4'h2: cpu_rdata = latch_q;
        4'h3: cpu_rdata = dsp_rdata;
        4'h4, 4'h5, 4'h6, 4'h7: cpu_rdata = host_q[off[1:0]];
        4'h8: cpu_rdata = scr_q[0];
        4'h9: cpu_rdata = scr_q[1];
        default: ;
      endcase
    end
  end

  a_r2_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (timer_en == $past(cpu_wdata[2:0])) && (rom_on == $past(cpu_wdata[7])));

  a_r3_clear_low_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cpu_wdata[4]) |=> (host_q[0] == 8'h00) && (host_q[1] == 8'h00));

  a_r3_clear_high_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cpu_wdata[5]) |=> (host_q[2] == 8'h00) && (host_q[3] == 8'h00));

  a_r4_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> (dsp_addr == $past(cpu_wdata[6:0])));

  a_r5_drop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_latch && cpu_wdata[7]) |=> !(cpu_wr && win && off == 4'h3 && dsp_we));

  a_r7_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && win && off == 4'h8) |=> (scr_q[0] == $past(cpu_wdata)));
endmodule

// File: tb/aud_io_decode_test.sv
module aud_io_decode_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_rdata;
  logic ram_we;
  logic [7:0] ram_rdata = '0;
  logic [6:0] dsp_addr;
  logic [7:0] dsp_wdata;
  logic dsp_we, dsp_re;
  logic [7:0] dsp_rdata = '0;
  logic host_we = 1'b0;
  logic [1:0] host_sel = '0;
  logic [7:0] host_wdata = '0;
  logic [2:0] timer_en;
  logic rom_on;

  int n_chk = 0, n_fail = 0;

  logic [2:0] m_ten;
  logic       m_rom;
  logic [7:0] m_latch;
  logic [7:0] m_scr [2];
  logic [7:0] m_host [4];

  always #2.5 clk = ~clk;

  aud_io_decode uut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [15:0] a, logic [7:0] rd_ram, logic [7:0] rd_dsp);
    if (m_rom && a >= 16'hFFC0) return 8'(8'h5B + 8'd37 * 8'(a[5:0]));
    if (a[15:4] == 12'h00F) begin
      case (a[3:0])
        4'h2: return m_latch;
        4'h3: return rd_dsp;
        4'h4, 4'h5, 4'h6, 4'h7: return m_host[a[1:0]];
        4'h8: return m_scr[0];
        4'h9: return m_scr[1];
        default: return rd_ram;
      endcase
    end
    return rd_ram;
  endfunction

  function automatic string tag_of(logic [15:0] a);
    if (a >= 16'hFFC0) return "R10";
    if (a[15:4] != 12'h00F) return "R11";
    case (a[3:0])
      4'h2: return "R4";
      4'h3: return "R6";
      4'h4, 4'h5, 4'h6, 4'h7: return "R9";
      4'h8, 4'h9: return "R7";
      default: return "R11";
    endcase
  endfunction

  // one cycle, entered and left just after a falling edge
  task automatic step(logic [15:0] a, logic [7:0] d, logic wr, logic rd,
                      logic hwe, logic [1:0] hs, logic [7:0] hd);
    logic [7:0] rr, dr;
    rr = 8'($urandom); dr = 8'($urandom);
    cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = rd;
    host_we = hwe; host_sel = hs; host_wdata = hd;
    ram_rdata = rr; dsp_rdata = dr;
    #1;
    chk("R8 ram_we", 16'(ram_we), 16'(wr));
    chk("R4 dsp_addr", 16'(dsp_addr), 16'(m_latch[6:0]));
    if (wr && a == 16'h00F3) begin
      chk("R5 dsp_we", 16'(dsp_we), 16'(!m_latch[7]));
      chk("R5 dsp_wdata", 16'(dsp_wdata), 16'(d));
    end else chk("R5 dsp_we idle", 16'(dsp_we), 16'h0);
    chk("R6 dsp_re", 16'(dsp_re), 16'(rd && a == 16'h00F3));
    if (rd) chk(tag_of(a), 16'(cpu_rdata), 16'(exp_rd(a, rr, dr)));
    @(posedge clk);
    if (hwe) m_host[hs] = hd;
    if (wr) begin
      if (a == 16'h00F1) begin
        m_ten = d[2:0]; m_rom = d[7];
        if (d[4]) begin m_host[0] = 0; m_host[1] = 0; end
        if (d[5]) begin m_host[2] = 0; m_host[3] = 0; end
      end
      if (a == 16'h00F2) m_latch = d;
      if (a == 16'h00F8) m_scr[0] = d;
      if (a == 16'h00F9) m_scr[1] = d;
    end
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; host_we = 0;
    chk("R2 timer_en", 16'(timer_en), 16'(m_ten));
    chk("R2 rom_on", 16'(rom_on), 16'(m_rom));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d); step(a, d, 1, 0, 0, 0, 0); endtask
  task automatic rd(logic [15:0] a); step(a, 0, 0, 1, 0, 0, 0); endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    m_ten = 0; m_rom = 1; m_latch = 0;
    for (int i = 0; i < 2; i++) m_scr[i] = 0;
    for (int i = 0; i < 4; i++) m_host[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rom_on", 16'(rom_on), 16'h1);
    chk("R1 timer_en", 16'(timer_en), 16'h0);
    rd(16'h00F2); rd(16'h00F4); rd(16'h00F7); rd(16'h00F8); rd(16'h00F9);
    // R10 overlay on, ROM write does not alter ROM reads
    rd(16'hFFC0); rd(16'hFFFF);
    wr(16'hFFC5, 8'h11); rd(16'hFFC5);
    rd(16'hFFBF);
    // R2 turn overlay off: reads fall through to RAM (R10)
    wr(16'h00F1, 8'h05); rd(16'hFFC5); rd(16'hFFFF);
    wr(16'h00F1, 8'h82);
    // R9 host ports, R3 pair clears
    for (int p = 0; p < 4; p++) step(16'h0000, 0, 0, 0, 1, 2'(p), 8'(8'hA0 + p));
    for (int p = 0; p < 4; p++) rd(16'(16'h00F4 + p));
    wr(16'h00F1, 8'h10);
    for (int p = 0; p < 4; p++) rd(16'(16'h00F4 + p));
    for (int p = 0; p < 4; p++) step(16'h0000, 0, 0, 0, 1, 2'(p), 8'(8'hC0 + p));
    wr(16'h00F1, 8'h20);
    for (int p = 0; p < 4; p++) rd(16'(16'h00F4 + p));
    // R3 clear wins over same-cycle host load
    step(16'h00F1, 8'h10, 1, 0, 1, 2'd1, 8'h77);
    rd(16'h00F5);
    step(16'h00F1, 8'h00, 1, 0, 1, 2'd3, 8'h66);
    rd(16'h00F7);
    // R4/R5/R6 DSP indirection
    wr(16'h00F2, 8'h7F); rd(16'h00F2); wr(16'h00F3, 8'h3C); rd(16'h00F3);
    wr(16'h00F2, 8'h80); rd(16'h00F2); wr(16'h00F3, 8'h3C); rd(16'h00F3);
    wr(16'h00F2, 8'hFF); wr(16'h00F3, 8'h01);
    // R7 scratch, R11 unused offsets
    wr(16'h00F8, 8'h5A); wr(16'h00F9, 8'hA5); rd(16'h00F8); rd(16'h00F9);
    rd(16'h00F0); rd(16'h00F1); rd(16'h00FA); rd(16'h00FF); rd(16'h01F3);
    // random mix
    for (int it = 0; it < 4000; it++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom % 10);
      case (k)
        0: wr(16'h00F1, 8'($urandom));
        1: wr(16'h00F2, 8'($urandom));
        2: wr(16'h00F3, 8'($urandom));
        3: step(16'(16'h00F0 + $urandom % 16), 8'($urandom), 1, 0,
                1'($urandom), 2'($urandom), 8'($urandom));
        4: step(16'h0000, 0, 0, 0, 1, 2'($urandom), 8'($urandom));
        5: rd(16'(16'hFFC0 + $urandom % 64));
        6: rd(16'($urandom));
        default: begin
          a = 16'(16'h00F0 + $urandom % 16);
          step(a, 0, 0, 1, 1'($urandom), 2'($urandom), 8'($urandom));
        end
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule